// File: doc/BRIEF.md
# Dual-Channel Serial DAC Update Controller

This block is the host-facing write path of a two-channel, 12-bit serial digital-to-analog converter. The host presents a 16-bit word, either in one wide write or as two byte writes. The word waits in a one-entry buffer. It then moves into a shift register and goes out serially, most significant bit first, to a converter model inside the block. The converter model decodes the channel field, keeps a 12-bit input register for each channel, and drives a 12-bit output level for each channel.

An update mode decides when the output levels change. In direct mode a channel's output follows its input register as soon as that channel's word is received. In the three synchronised modes, words collect in the input registers and both outputs load together on one event. The event is a timer overflow pulse, a synchronised rising edge of an external gate, or a pacer tick, depending on the mode. A status byte reports whether the buffer is occupied. It also reports whether a word was ever dropped because the buffer was full.

Top module: `dac_link_ctrl`

## Requirements
- R1: Bits 11:0 of a word are the two's-complement sample and bits 15:12 select the channel: 0 selects channel 0 and 1 selects channel 1. A word with any other channel code goes out on the serial link but leaves both channel outputs unchanged.
- R2: A wide write (`wr_wide`=1) to address 8 commits `wr_data` as a word. A byte write (`wr_wide`=0) to address 8 stores `wr_data[7:0]` as the low byte and commits nothing. A byte write to address 9 commits the word {`wr_data[7:0]`, stored low byte}.
- R3: `status_o[5]` is 1 from the clock edge that commits a word until the edge where that word moves into the shift register. It is 0 otherwise.
- R4: The serial link sends the 16 word bits MSB first, one bit per `bit_tick`. `ser_frame` stays high for exactly 16 `bit_tick` periods per word.
- R5: A commit that arrives while the buffer is occupied is dropped and sets `status_o[6]`. That bit stays 1 until reset.
- R6: In mode 0, the output of the addressed channel takes the new sample on the edge where the 16th bit is received. The other channel's output does not change.
- R7: In mode 1, both outputs stay unchanged when words arrive. On a `tmr_ovf` pulse both outputs load their input registers together.
- R8: In mode 2, `gate_in` passes through a two-flop synchroniser. Only a low-to-high transition loads both outputs. A gate level that is held high, and a falling edge, have no effect.
- R9: In mode 3, a `pacer_tick` pulse loads both outputs from their input registers.
- R10: In a synchronised mode, the events of the other synchronised modes do not change the outputs.
- R11: After reset both outputs are 0, `status_o` is 0 and `ser_frame` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_wide | input | 1 | 1 = 16-bit write, 0 = byte write |
| wr_addr | input | 4 | Write address (8 = low/word, 9 = high byte) |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| mode_sel | input | 2 | Update mode 0..3 |
| tmr_ovf | input | 1 | Timer overflow pulse (mode 1 event) |
| gate_in | input | 1 | Asynchronous external gate (mode 2 event) |
| pacer_tick | input | 1 | Pacer clock pulse (mode 3 event) |
| bit_tick | input | 1 | Serial bit enable |
| status_o | output | 8 | Bit 5 buffer occupied, bit 6 sticky overrun, other bits 0 |
| ser_data | output | 1 | Serial data, MSB first |
| ser_frame | output | 1 | High while a word is being shifted |
| ch0_level | output | 12 | Channel 0 output register |
| ch1_level | output | 12 | Channel 1 output register |

## Verification
A table of direct-mode words covers several cases. It alternates channels, so that a mix-up between channel 0 and channel 1 shows. It uses sign-boundary samples (0x800, 0x7FF, 0xFFF), so that a truncated or reordered serial word shows. It includes a word with channel code 2, which separates a correct channel decode from one that tests only bit 12. Byte-pair writes show whether the commit happens on the high byte and not on the low byte. Holding `bit_tick` low stalls the shifter, so that three back-to-back writes show the buffer freeing early and the third word being dropped. In each synchronised mode, words are sent while the outputs are watched, then the events of the wrong modes are applied, then the correct event. A held gate level and a falling edge separate true edge detection from level sensing.

// File: rtl/dac_link_pkg.sv
`timescale 1ns/1ps
package dac_link_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT = 2'd0,
    MODE_TIMER  = 2'd1,
    MODE_GATE   = 2'd2,
    MODE_PACER  = 2'd3
  } upd_mode_e;

  localparam int STAT_BUSY_BIT = 5;
  localparam int STAT_OVR_BIT  = 6;
endpackage

// File: rtl/dac_host_port.sv
`timescale 1ns/1ps
module dac_host_port #(
  parameter int WORD_W  = 16,
  parameter int ADDR_W  = 4,
  parameter int ADDR_LO = 8,
  parameter int ADDR_HI = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              take,
  output logic [WORD_W-1:0] buf_word,
  output logic              buf_full,
  output logic              overrun
);
  localparam int BYTE_W = WORD_W / 2;

  logic [BYTE_W-1:0] lo_hold;
  logic              commit;
  logic              accept;
  logic              lo_wr;
  logic [WORD_W-1:0] new_word;

  always_comb begin
    commit   = 1'b0;
    lo_wr    = 1'b0;
    new_word = {wr_data[BYTE_W-1:0], lo_hold};
    if (wr_en) begin
      if (wr_wide && wr_addr == ADDR_W'(ADDR_LO)) begin
        commit   = 1'b1;
        new_word = wr_data;
      end else if (!wr_wide && wr_addr == ADDR_W'(ADDR_LO)) begin
        lo_wr = 1'b1;
      end else if (!wr_wide && wr_addr == ADDR_W'(ADDR_HI)) begin
        commit = 1'b1;
      end
    end
  end

  assign accept = commit && (!buf_full || take);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_hold  <= '0;
      buf_word <= '0;
      buf_full <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (lo_wr) lo_hold <= wr_data[BYTE_W-1:0];
      if (accept) begin
        buf_word <= new_word;
        buf_full <= 1'b1;
      end else if (take) begin
        buf_full <= 1'b0;
      end
      if (commit && !accept) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/dac_serializer.sv
`timescale 1ns/1ps
module dac_serializer #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              buf_full,
  input  logic [WORD_W-1:0] buf_word,
  output logic              take,
  output logic              ser_data,
  output logic              ser_frame
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  left;
  logic              active;

  assign take      = buf_full && !active;
  assign ser_data  = sh[WORD_W-1];
  assign ser_frame = active;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      left   <= '0;
      active <= 1'b0;
    end else if (take) begin
      sh     <= buf_word;
      left   <= CNT_W'(WORD_W);
      active <= 1'b1;
    end else if (active && bit_tick) begin
      sh   <= {sh[WORD_W-2:0], 1'b0};
      left <= left - 1'b1;
      if (left == CNT_W'(1)) active <= 1'b0;
    end
  end
endmodule

// File: rtl/dac_event_sel.sv
`timescale 1ns/1ps
module dac_event_sel
  import dac_link_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       tmr_ovf,
  input  logic       gate_in,
  input  logic       pacer_tick,
  output logic       upd_evt
);
  logic [SYNC_STAGES-1:0] gsync;
  logic                   gate_prev;
  logic                   gate_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      gsync     <= '0;
      gate_prev <= 1'b0;
    end else begin
      gsync     <= {gsync[SYNC_STAGES-2:0], gate_in};
      gate_prev <= gsync[SYNC_STAGES-1];
    end
  end

  assign gate_rise = gsync[SYNC_STAGES-1] && !gate_prev;

  always_comb begin
    case (upd_mode_e'(mode))
      MODE_TIMER: upd_evt = tmr_ovf;
      MODE_GATE:  upd_evt = gate_rise;
      MODE_PACER: upd_evt = pacer_tick;
      default:    upd_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/dac_conv_model.sv
`timescale 1ns/1ps
module dac_conv_model #(
  parameter int WORD_W   = 16,
  parameter int SAMPLE_W = 12,
  parameter int NUM_CH   = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             bit_tick,
  input  logic                             ser_data,
  input  logic                             ser_frame,
  input  logic                             direct,
  input  logic                             upd_evt,
  output logic [NUM_CH-1:0][SAMPLE_W-1:0]  out_lvl
);
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int CHAN_W = WORD_W - SAMPLE_W;

  logic [WORD_W-2:0] rx_sh;
  logic [CNT_W-1:0]  rx_cnt;
  logic              word_done;
  logic [WORD_W-1:0] rx_word;
  logic [CHAN_W-1:0] rx_chan;

  assign word_done = ser_frame && bit_tick && (rx_cnt == CNT_W'(WORD_W - 1));
  assign rx_word   = {rx_sh, ser_data};
  assign rx_chan   = rx_word[WORD_W-1:SAMPLE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh  <= '0;
      rx_cnt <= '0;
    end else if (!ser_frame) begin
      rx_cnt <= '0;
    end else if (bit_tick) begin
      rx_sh  <= rx_word[WORD_W-2:0];
      rx_cnt <= rx_cnt + 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SAMPLE_W-1:0] in_reg;
    logic                hit;
    assign hit = word_done && (rx_chan == CHAN_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        in_reg     <= '0;
        out_lvl[c] <= '0;
      end else begin
        if (hit) in_reg <= rx_word[SAMPLE_W-1:0];
        if (direct) begin
          if (hit) out_lvl[c] <= rx_word[SAMPLE_W-1:0];
        end else if (upd_evt) begin
          out_lvl[c] <= in_reg;
        end
      end
    end
  end
endmodule

// File: rtl/dac_link_ctrl.sv
`timescale 1ns/1ps
module dac_link_ctrl
  import dac_link_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int SAMPLE_W = 12,
  parameter int ADDR_W   = 4,
  parameter int ADDR_LO  = 8,
  parameter int ADDR_HI  = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                wr_wide,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0]   wr_data,
  input  logic [1:0]          mode_sel,
  input  logic                tmr_ovf,
  input  logic                gate_in,
  input  logic                pacer_tick,
  input  logic                bit_tick,
  output logic [7:0]          status_o,
  output logic                ser_data,
  output logic                ser_frame,
  output logic [SAMPLE_W-1:0] ch0_level,
  output logic [SAMPLE_W-1:0] ch1_level
);
  localparam int NUM_CH = 2;

  logic [WORD_W-1:0]               buf_word;
  logic                            buf_full;
  logic                            overrun;
  logic                            take;
  logic                            upd_evt;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] lvl;

  dac_host_port #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
  ) u_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_wide(wr_wide),
    .wr_addr(wr_addr), .wr_data(wr_data), .take(take),
    .buf_word(buf_word), .buf_full(buf_full), .overrun(overrun)
  );

  dac_serializer #(.WORD_W(WORD_W)) u_ser (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .buf_full(buf_full),
    .buf_word(buf_word), .take(take), .ser_data(ser_data), .ser_frame(ser_frame)
  );

  dac_event_sel #(.SYNC_STAGES(2)) u_evt (
    .clk(clk), .rst(rst), .mode(mode_sel), .tmr_ovf(tmr_ovf),
    .gate_in(gate_in), .pacer_tick(pacer_tick), .upd_evt(upd_evt)
  );

  dac_conv_model #(.WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) u_conv (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .ser_data(ser_data),
    .ser_frame(ser_frame), .direct(mode_sel == MODE_DIRECT),
    .upd_evt(upd_evt), .out_lvl(lvl)
  );

  always_comb begin
    status_o = '0;
    status_o[STAT_BUSY_BIT] = buf_full;
    status_o[STAT_OVR_BIT]  = overrun;
  end

  assign ch0_level = lvl[0];
  assign ch1_level = lvl[1];
endmodule

// File: rtl/dac_link_chk.sv
`timescale 1ns/1ps
module dac_link_chk #(
  parameter int WORD_W   = 16,
  parameter int SAMPLE_W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                bit_tick,
  input logic [1:0]          mode_sel,
  input logic [7:0]          status_o,
  input logic                ser_frame,
  input logic [SAMPLE_W-1:0] ch0_level,
  input logic [SAMPLE_W-1:0] ch1_level,
  input logic                upd_evt
);
  localparam int TC_W = $clog2(WORD_W + 2);
  logic [TC_W-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (rst)                        tick_cnt <= '0;
    else if (ser_frame && bit_tick) tick_cnt <= tick_cnt + 1'b1;
    else if (!ser_frame)            tick_cnt <= '0;
  end

  AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[5]) |-> $past(wr_en)); // R3

  AST_FRAME_TICK_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_frame) |-> (tick_cnt == TC_W'(WORD_W))); // R4

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    status_o[6] |=> status_o[6]); // R5

  AST_SYNC_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != 2'd0 && !upd_evt) |=> ($stable(ch0_level) && $stable(ch1_level))); // R7

  AST_GATE_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'd2 && upd_evt) |=> !upd_evt); // R8
endmodule

bind dac_link_ctrl dac_link_chk #(.WORD_W(WORD_W), .SAMPLE_W(SAMPLE_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .bit_tick(bit_tick),
  .mode_sel(mode_sel), .status_o(status_o), .ser_frame(ser_frame),
  .ch0_level(ch0_level), .ch1_level(ch1_level), .upd_evt(upd_evt)
);

// File: tb/dac_link_ctrl_tb_top.sv
`timescale 1ns/1ps
module dac_link_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_wide = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  mode_sel = 2'd0;
  logic        tmr_ovf = 1'b0, gate_in = 1'b0, pacer_tick = 1'b0;
  logic        bit_tick = 1'b1;
  logic [7:0]  status_o;
  logic        ser_data, ser_frame;
  logic [11:0] ch0_level, ch1_level;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] cap = '0, last_cap = '0;
  int          cap_n = 0, last_n = 0;
  logic        frame_d = 1'b0;

  always #4 clk = ~clk;

  dac_link_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_wide(wr_wide), .wr_addr(wr_addr),
    .wr_data(wr_data), .mode_sel(mode_sel), .tmr_ovf(tmr_ovf), .gate_in(gate_in),
    .pacer_tick(pacer_tick), .bit_tick(bit_tick), .status_o(status_o),
    .ser_data(ser_data), .ser_frame(ser_frame), .ch0_level(ch0_level),
    .ch1_level(ch1_level)
  );

  // serial capture, sampled mid-cycle
  always @(negedge clk) begin
    if (ser_frame) begin
      if (bit_tick) begin
        cap   = {cap[14:0], ser_data};
        cap_n = cap_n + 1;
      end
    end else if (frame_d) begin
      last_cap = cap;
      last_n   = cap_n;
      cap_n    = 0;
    end
    frame_d = ser_frame;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wide_write(input logic [15:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_wide = 1'b1; wr_addr = 4'd8; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0; wr_wide = 1'b0;
  endtask

  task automatic byte_write(input logic [3:0] a, input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_wide = 1'b0; wr_addr = a; wr_data = {8'h00, b};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
  endtask

  task automatic pulse_pacer();
    @(negedge clk); pacer_tick = 1'b1; @(negedge clk); pacer_tick = 1'b0;
  endtask

  // {word, expected ch0, expected ch1} in direct mode
  localparam logic [39:0] VEC [6] = '{
    {16'h0123, 12'h123, 12'h000},
    {16'h1ABC, 12'h123, 12'hABC},
    {16'h0800, 12'h800, 12'hABC},
    {16'h17FF, 12'h800, 12'h7FF},
    {16'h2555, 12'h800, 12'h7FF},
    {16'h0FFF, 12'hFFF, 12'h7FF}
  };

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    @(negedge clk);
    check("R11 status", 32'(status_o), 32'h0);
    check("R11 ch0", 32'(ch0_level), 32'h0);
    check("R11 ch1", 32'(ch1_level), 32'h0);
    check("R11 frame", 32'(ser_frame), 32'h0);

    // R1 R4 R6: direct mode table
    for (int i = 0; i < 6; i++) begin
      wide_write(VEC[i][39:24]);
      wait_cyc(22);
      check("R6/R1 ch0", 32'(ch0_level), 32'(VEC[i][23:12]));
      check("R6/R1 ch1", 32'(ch1_level), 32'(VEC[i][11:0]));
      check("R4 serial word", 32'(last_cap), 32'(VEC[i][39:24]));
      check("R4 bit count", 32'(last_n), 32'd16);
    end

    // R2 R3: byte writes
    byte_write(4'd8, 8'h34);
    wait_cyc(3);
    check("R2 low byte no commit busy", 32'(status_o[5]), 32'h0);
    check("R2 low byte no frame", 32'(ser_frame), 32'h0);
    byte_write(4'd9, 8'h02);
    check("R3 busy after commit", 32'(status_o[5]), 32'h1);
    @(negedge clk);
    check("R3 busy cleared on load", 32'(status_o[5]), 32'h0);
    wait_cyc(22);
    check("R2 byte pair ch0", 32'(ch0_level), 32'h234);
    check("R2 byte pair ch1", 32'(ch1_level), 32'h7FF);

    // R5: overrun with stalled shifter
    bit_tick = 1'b0;
    wide_write(16'h0111);
    @(negedge clk);
    check("R3 buffer freed while shifting", 32'(status_o[5]), 32'h0);
    wide_write(16'h1222);
    check("R5 busy before drop", 32'(status_o[6:5]), 32'h1);
    wide_write(16'h0333);
    check("R5 overrun set", 32'(status_o[6:5]), 32'h3);
    bit_tick = 1'b1;
    wait_cyc(45);
    check("R5 ch0 kept first word", 32'(ch0_level), 32'h111);
    check("R5 ch1 second word", 32'(ch1_level), 32'h222);
    check("R5 overrun sticky", 32'(status_o), 32'h40);

    // R7 R10: timer mode
    mode_sel = 2'd1;
    wide_write(16'h0444); wait_cyc(22);
    wide_write(16'h1555); wait_cyc(22);
    check("R7 hold ch0", 32'(ch0_level), 32'h111);
    check("R7 hold ch1", 32'(ch1_level), 32'h222);
    pulse_pacer(); gate_in = 1'b1; wait_cyc(5); gate_in = 1'b0; wait_cyc(4);
    check("R10 wrong event ch0", 32'(ch0_level), 32'h111);
    pulse_tmr();
    check("R7 update ch0", 32'(ch0_level), 32'h444);
    check("R7 update ch1", 32'(ch1_level), 32'h555);

    // R8 R10: gate mode
    mode_sel = 2'd2;
    wide_write(16'h0666); wait_cyc(22);
    wide_write(16'h1777); wait_cyc(22);
    pulse_tmr(); pulse_pacer(); wait_cyc(2);
    check("R10 wrong event gate mode", 32'(ch0_level), 32'h444);
    @(negedge clk); gate_in = 1'b1;
    wait_cyc(6);
    check("R8 rise ch0", 32'(ch0_level), 32'h666);
    check("R8 rise ch1", 32'(ch1_level), 32'h777);
    wide_write(16'h0888); wait_cyc(22);
    check("R8 held level no effect", 32'(ch0_level), 32'h666);
    gate_in = 1'b0; wait_cyc(6);
    check("R8 fall no effect", 32'(ch0_level), 32'h666);
    gate_in = 1'b1; wait_cyc(6);
    check("R8 second rise", 32'(ch0_level), 32'h888);

    // R9: pacer mode
    mode_sel = 2'd3;
    gate_in = 1'b0;
    wide_write(16'h0999); wait_cyc(22);
    wide_write(16'h1AAA); wait_cyc(22);
    check("R9 hold ch1", 32'(ch1_level), 32'h777);
    pulse_pacer();
    check("R9 pacer ch0", 32'(ch0_level), 32'h999);
    check("R9 pacer ch1", 32'(ch1_level), 32'hAAA);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule